// File: doc/BRIEF.md
# Shared PHY Power Sequencer

This block powers a multi-lane PHY up and down for up to four independent lane users. Each lane has a power-on and a power-off request. A shared use count makes sure the PLL bring-up runs only for the request that raises the count from zero. It also makes sure PHY reset is reasserted only by the power-off that brings the count back to zero. Every request also updates that lane's idle bit.

A bring-up releases PHY reset and selects the PLL lock status on the config address port. It waits for lock, then programs two clock configuration entries through an address/data/strobe port. Next it waits for the PLL output pending flag to clear. It then reselects the lock status and waits for the PLL to relock. Status is sampled only on a poll tick. One deadline, started when the bring-up begins, covers all three waits. If the deadline expires, the block reasserts reset, restores the lane's idle bit, takes back the count and reports an error to the requester.

Requests are taken one at a time. Pulses that arrive while a sequence runs are held until the sequencer returns to idle.

Top module: `phy_pwr_seq`

## Requirements
- R1: After reset, every lane idle bit is 1, PHY reset is asserted, the config strobe is low and no done or error pulse is present.
- R2: A power-on taken while the count is 0 clears that lane's idle bit and deasserts PHY reset. It writes config address 0x10 with data 0x8, then address 0x12 with data 0x8. It leaves the address at 0x10 and pulses done for that lane once the PLL has locked, the output pending flag is low, and the PLL has relocked.
- R3: A power-on taken while the count is above 0 clears the lane's idle bit and pulses done. It makes no config write, and PHY reset stays deasserted.
- R4: A power-off taken while the count is above 0 sets the lane's idle bit, decrements the count and pulses done. PHY reset is asserted only when the count reaches 0.
- R5: A power-off taken while the count is 0 pulses error for that lane and leaves PHY reset asserted and the idle bit set.
- R6: One deadline of DEADLINE_CYC cycles, started when the bring-up begins, bounds all three waits together. It is not restarted between waits, and a bring-up never fails before it runs out.
- R7: On a bring-up timeout, PHY reset is reasserted, the lane's idle bit is set again, the count returns to its prior value and error is pulsed. The next power-on therefore runs a full bring-up.
- R8: A config write presents address and data for at least one cycle before the strobe rises. The strobe is high for exactly one cycle, and only while PHY reset is deasserted.
- R9: Requests arriving while a sequence runs are held and served afterwards. Among pending requests the lowest lane goes first, and within one lane power-on goes before power-off.
- R10: Done and error are one-cycle pulses, and at most one of them is high in any cycle across all lanes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwr_on_req_i | input | NUM_LANES | Per-lane power-on request pulse |
| pwr_off_req_i | input | NUM_LANES | Per-lane power-off request pulse |
| pll_locked_i | input | 1 | PLL lock status |
| pll_out_pend_i | input | 1 | PLL output enable still pending |
| cfg_addr_o | output | 6 | Config address / status select |
| cfg_data_o | output | 4 | Config write data |
| cfg_wr_o | output | 1 | Config write strobe |
| lane_idle_o | output | NUM_LANES | Per-lane idle control, 1 = idle |
| phy_rst_o | output | 1 | PHY reset, 1 = asserted |
| done_o | output | NUM_LANES | Per-lane request completed pulse |
| err_o | output | NUM_LANES | Per-lane request failed pulse |

## Verification
The hardest case to reach from the ports is proving that the deadline is shared, not restarted at each wait. The bench's PLL model locks quickly and then holds the output pending flag high. The error must therefore arrive within a few cycles of one deadline measured from the request, which a restarted timer would overshoot. Queue ordering needs requests to arrive while the sequencer is busy. The bench gets there by pulsing two lanes, or both requests of one lane, in the same cycle from idle, so that one bring-up runs while the others wait.

// File: rtl/phy_pwr_pkg.sv
package phy_pwr_pkg;
  localparam int CFG_AW = 6;
  localparam int CFG_DW = 4;

  localparam logic [CFG_AW-1:0] ADDR_LOCK_SEL = 6'h10;
  localparam logic [CFG_AW-1:0] ADDR_CLK_A    = 6'h10;
  localparam logic [CFG_AW-1:0] ADDR_CLK_B    = 6'h12;
  localparam logic [CFG_DW-1:0] CLK_CFG_DATA  = 4'h8;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_REL,
    ST_WAIT_LOCK,
    ST_WR_SET,
    ST_WR_STB,
    ST_WR_DROP,
    ST_WAIT_OUT,
    ST_RESEL,
    ST_WAIT_RELOCK
  } seq_state_e;
endpackage

// File: rtl/pwr_req_queue.sv
module pwr_req_queue #(
  parameter int NL = 4,
  localparam int NR = 2 * NL,
  localparam int IW = $clog2(NR)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NL-1:0] on_req_i,
  input  logic [NL-1:0] off_req_i,
  input  logic          take_i,
  output logic          valid_o,
  output logic [IW-1:0] idx_o
);
  logic [NR-1:0] req_flat;
  logic [NR-1:0] pend_q;
  logic [NR-1:0] clr;

  // slot 2l = power-on of lane l, slot 2l+1 = power-off
  for (genvar l = 0; l < NL; l++) begin : g_flat
    assign req_flat[2*l]   = on_req_i[l];
    assign req_flat[2*l+1] = off_req_i[l];
  end

  always_comb begin
    valid_o = 1'b0;
    idx_o   = '0;
    for (int i = NR - 1; i >= 0; i--) begin
      if (pend_q[i]) begin
        valid_o = 1'b1;
        idx_o   = IW'(i);
      end
    end
  end

  always_comb begin
    clr = '0;
    if (take_i && valid_o) clr[idx_o] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= (pend_q & ~clr) | req_flat;
  end
endmodule

// File: rtl/pwr_poll_timer.sv
module pwr_poll_timer #(
  parameter int POLL_CYC     = 4,
  parameter int DEADLINE_CYC = 200,
  localparam int PW = (POLL_CYC > 1) ? $clog2(POLL_CYC) : 1,
  localparam int DW = $clog2(DEADLINE_CYC + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic stop_i,
  output logic tick_o,
  output logic expired_o
);
  logic          run_q;
  logic [PW-1:0] poll_q;
  logic [DW-1:0] dl_q;

  assign tick_o    = run_q && (poll_q == PW'(POLL_CYC - 1));
  assign expired_o = run_q && (dl_q == DW'(DEADLINE_CYC));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      poll_q <= '0;
      dl_q   <= '0;
    end else if (start_i) begin
      // first sample lands on the first wait cycle
      run_q  <= 1'b1;
      poll_q <= PW'(POLL_CYC - 1);
      dl_q   <= '0;
    end else if (stop_i) begin
      run_q <= 1'b0;
    end else if (run_q) begin
      poll_q <= tick_o ? '0 : poll_q + PW'(1);
      if (!expired_o) dl_q <= dl_q + DW'(1);
    end
  end
endmodule

// File: rtl/phy_pwr_seq.sv
module phy_pwr_seq
  import phy_pwr_pkg::*;
#(
  parameter int NUM_LANES    = 4,
  parameter int POLL_CYC     = 2_000_000,
  parameter int DEADLINE_CYC = 100_000_000
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LANES-1:0] pwr_on_req_i,
  input  logic [NUM_LANES-1:0] pwr_off_req_i,
  input  logic                 pll_locked_i,
  input  logic                 pll_out_pend_i,
  output logic [CFG_AW-1:0]    cfg_addr_o,
  output logic [CFG_DW-1:0]    cfg_data_o,
  output logic                 cfg_wr_o,
  output logic [NUM_LANES-1:0] lane_idle_o,
  output logic                 phy_rst_o,
  output logic [NUM_LANES-1:0] done_o,
  output logic [NUM_LANES-1:0] err_o
);
  localparam int LW    = $clog2(NUM_LANES);
  localparam int IW    = $clog2(2 * NUM_LANES);
  localparam int CNT_W = $clog2(NUM_LANES + 1) + 1;

  seq_state_e            state_q;
  logic [LW-1:0]         lane_q;
  logic [CNT_W-1:0]      use_cnt_q;
  logic                  wr_idx_q;
  logic [CFG_AW-1:0]     addr_q;
  logic [CFG_DW-1:0]     data_q;
  logic                  wr_q;
  logic                  rst_q;
  logic [NUM_LANES-1:0]  idle_q;
  logic [NUM_LANES-1:0]  done_q;
  logic [NUM_LANES-1:0]  err_q;

  logic                  q_valid;
  logic [IW-1:0]         q_idx;
  logic                  take;
  logic                  tick;
  logic                  expired;
  logic [LW-1:0]         sel_lane;
  logic                  sel_off;

  assign take     = (state_q == ST_IDLE);
  assign sel_lane = q_idx[IW-1:1];
  assign sel_off  = q_idx[0];

  pwr_req_queue #(.NL(NUM_LANES)) u_queue (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .on_req_i  (pwr_on_req_i),
    .off_req_i (pwr_off_req_i),
    .take_i    (take),
    .valid_o   (q_valid),
    .idx_o     (q_idx)
  );

  pwr_poll_timer #(.POLL_CYC(POLL_CYC), .DEADLINE_CYC(DEADLINE_CYC)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (state_q == ST_REL),
    .stop_i    (state_q == ST_IDLE),
    .tick_o    (tick),
    .expired_o (expired)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      lane_q    <= '0;
      use_cnt_q <= '0;
      wr_idx_q  <= 1'b0;
      addr_q    <= '0;
      data_q    <= '0;
      wr_q      <= 1'b0;
      rst_q     <= 1'b1;
      idle_q    <= '1;
      done_q    <= '0;
      err_q     <= '0;
    end else begin
      done_q <= '0;
      err_q  <= '0;
      wr_q   <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (q_valid) begin
            lane_q <= sel_lane;
            if (sel_off) begin
              idle_q[sel_lane] <= 1'b1;
              if (use_cnt_q == '0) begin
                err_q[sel_lane] <= 1'b1;
              end else begin
                use_cnt_q        <= use_cnt_q - CNT_W'(1);
                done_q[sel_lane] <= 1'b1;
                if (use_cnt_q == CNT_W'(1)) rst_q <= 1'b1;
              end
            end else begin
              idle_q[sel_lane] <= 1'b0;
              use_cnt_q        <= use_cnt_q + CNT_W'(1);
              if (use_cnt_q == '0) state_q <= ST_REL;
              else                 done_q[sel_lane] <= 1'b1;
            end
          end
        end
        ST_REL: begin
          rst_q   <= 1'b0;
          addr_q  <= ADDR_LOCK_SEL;
          state_q <= ST_WAIT_LOCK;
        end
        ST_WAIT_LOCK: begin
          if (tick && pll_locked_i) begin
            wr_idx_q <= 1'b0;
            state_q  <= ST_WR_SET;
          end else if (expired) begin
            rst_q          <= 1'b1;
            use_cnt_q      <= use_cnt_q - CNT_W'(1);
            idle_q[lane_q] <= 1'b1;
            err_q[lane_q]  <= 1'b1;
            state_q        <= ST_IDLE;
          end
        end
        ST_WR_SET: begin
          addr_q  <= wr_idx_q ? ADDR_CLK_B : ADDR_CLK_A;
          data_q  <= CLK_CFG_DATA;
          state_q <= ST_WR_STB;
        end
        ST_WR_STB: begin
          wr_q    <= 1'b1;
          state_q <= ST_WR_DROP;
        end
        ST_WR_DROP: begin
          if (!wr_idx_q) begin
            wr_idx_q <= 1'b1;
            state_q  <= ST_WR_SET;
          end else begin
            state_q  <= ST_WAIT_OUT;
          end
        end
        ST_WAIT_OUT: begin
          if (tick && !pll_out_pend_i) begin
            state_q <= ST_RESEL;
          end else if (expired) begin
            rst_q          <= 1'b1;
            use_cnt_q      <= use_cnt_q - CNT_W'(1);
            idle_q[lane_q] <= 1'b1;
            err_q[lane_q]  <= 1'b1;
            state_q        <= ST_IDLE;
          end
        end
        ST_RESEL: begin
          addr_q  <= ADDR_LOCK_SEL;
          state_q <= ST_WAIT_RELOCK;
        end
        ST_WAIT_RELOCK: begin
          if (tick && pll_locked_i) begin
            done_q[lane_q] <= 1'b1;
            state_q        <= ST_IDLE;
          end else if (expired) begin
            rst_q          <= 1'b1;
            use_cnt_q      <= use_cnt_q - CNT_W'(1);
            idle_q[lane_q] <= 1'b1;
            err_q[lane_q]  <= 1'b1;
            state_q        <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cfg_addr_o  = addr_q;
  assign cfg_data_o  = data_q;
  assign cfg_wr_o    = wr_q;
  assign lane_idle_o = idle_q;
  assign phy_rst_o   = rst_q;
  assign done_o      = done_q;
  assign err_o       = err_q;
endmodule

// File: rtl/phy_pwr_seq_chk.sv
module phy_pwr_seq_chk #(
  parameter int NL = 4,
  parameter int CW = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [5:0]    cfg_addr_o,
  input logic [3:0]    cfg_data_o,
  input logic          cfg_wr_o,
  input logic          phy_rst_o,
  input logic [NL-1:0] done_o,
  input logic [NL-1:0] err_o,
  input logic [CW-1:0] use_cnt
);
  AST_STB_ONE_CYC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_wr_o |=> !cfg_wr_o); // R8
  AST_STB_SETUP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cfg_wr_o) |-> ($stable(cfg_addr_o) && $stable(cfg_data_o))); // R8
  AST_STB_OUT_OF_RST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_wr_o |-> !phy_rst_o); // R8
  AST_RESP_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({done_o, err_o})); // R10
  AST_RST_RISE_RESP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(phy_rst_o) |-> (|(done_o | err_o))); // R4
  AST_RST_FALL_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(phy_rst_o) |-> (use_cnt == CW'(1))); // R2
  AST_RUN_NEEDS_USER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !phy_rst_o |-> (use_cnt != '0)); // R7
endmodule

bind phy_pwr_seq phy_pwr_seq_chk #(.NL(NUM_LANES), .CW(CNT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cfg_addr_o (cfg_addr_o),
  .cfg_data_o (cfg_data_o),
  .cfg_wr_o   (cfg_wr_o),
  .phy_rst_o  (phy_rst_o),
  .done_o     (done_o),
  .err_o      (err_o),
  .use_cnt    (use_cnt_q)
);

// File: tb/tb_phy_pwr_seq.sv
module tb_phy_pwr_seq;
  localparam int NL   = 4;
  localparam int POLL = 4;
  localparam int DL   = 200;
  localparam int LOCK_DLY = 12;

  localparam logic [1:0] M_GOOD = 2'd0, M_NOLOCK = 2'd1, M_STUCK = 2'd2, M_NORELOCK = 2'd3;

  typedef struct packed {
    logic       off;
    logic [1:0] lane;
    logic [1:0] mode;
    logic       err;
    logic       rst;
    logic       idle;
    logic [1:0] wr;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 2'd0, M_GOOD,     1'b0, 1'b0, 1'b0, 2'd2},
    '{1'b0, 2'd1, M_GOOD,     1'b0, 1'b0, 1'b0, 2'd0},
    '{1'b1, 2'd0, M_GOOD,     1'b0, 1'b0, 1'b1, 2'd0},
    '{1'b1, 2'd1, M_GOOD,     1'b0, 1'b1, 1'b1, 2'd0},
    '{1'b0, 2'd2, M_NOLOCK,   1'b1, 1'b1, 1'b1, 2'd0},
    '{1'b0, 2'd2, M_STUCK,    1'b1, 1'b1, 1'b1, 2'd2},
    '{1'b0, 2'd3, M_NORELOCK, 1'b1, 1'b1, 1'b1, 2'd2},
    '{1'b0, 2'd3, M_GOOD,     1'b0, 1'b0, 1'b0, 2'd2},
    '{1'b1, 2'd3, M_GOOD,     1'b0, 1'b1, 1'b1, 2'd0},
    '{1'b1, 2'd0, M_GOOD,     1'b1, 1'b1, 1'b1, 2'd0}
  };

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [NL-1:0] pwr_on_req_i = '0;
  logic [NL-1:0] pwr_off_req_i = '0;
  logic          pll_locked_i;
  logic          pll_out_pend_i;
  logic [5:0]    cfg_addr_o;
  logic [3:0]    cfg_data_o;
  logic          cfg_wr_o;
  logic [NL-1:0] lane_idle_o;
  logic          phy_rst_o;
  logic [NL-1:0] done_o;
  logic [NL-1:0] err_o;

  int n_chk = 0;
  int n_fail = 0;
  logic [1:0] mode = M_GOOD;
  int rel_cnt = 0;
  int wr_cnt = 0;
  int total_wr = 0;
  logic [5:0] prev_addr = '0;
  logic [3:0] prev_data = '0;

  always #10 clk_i = ~clk_i;

  phy_pwr_seq #(.NUM_LANES(NL), .POLL_CYC(POLL), .DEADLINE_CYC(DL)) dut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // PLL model
  assign pll_locked_i = (mode != M_NOLOCK) && (rel_cnt >= LOCK_DLY) &&
                        !((mode == M_NORELOCK) && (wr_cnt >= 2));
  assign pll_out_pend_i = (mode == M_STUCK) || (wr_cnt < 2);

  always @(negedge clk_i) begin
    if (phy_rst_o) begin
      rel_cnt = 0;
      wr_cnt  = 0;
    end else begin
      rel_cnt++;
      if (cfg_wr_o) begin
        // R2 write order, R8 setup
        chk(cfg_addr_o == ((wr_cnt == 0) ? 6'h10 : 6'h12), "R2 cfg addr",
            int'(cfg_addr_o), (wr_cnt == 0) ? 16 : 18);
        chk(cfg_data_o == 4'h8, "R2 cfg data", int'(cfg_data_o), 8);
        chk(prev_addr == cfg_addr_o && prev_data == cfg_data_o, "R8 setup",
            int'(prev_addr), int'(cfg_addr_o));
        wr_cnt++;
        total_wr++;
      end
    end
    prev_addr = cfg_addr_o;
    prev_data = cfg_data_o;
  end

  task automatic pulse(input logic [NL-1:0] on_v, input logic [NL-1:0] off_v);
    @(negedge clk_i);
    pwr_on_req_i  = on_v;
    pwr_off_req_i = off_v;
    @(negedge clk_i);
    pwr_on_req_i  = '0;
    pwr_off_req_i = '0;
  endtask

  task automatic wait_resp(input int lane, output bit got_err, output int cyc);
    got_err = 1'b0;
    cyc = 1;
    for (int k = 0; k < 3000; k++) begin
      chk(!(|(done_o & err_o)), "R10 exclusive", int'(done_o), 0);
      if (done_o[lane] || err_o[lane]) begin
        got_err = err_o[lane];
        return;
      end
      @(negedge clk_i);
      cyc++;
    end
    chk(1'b0, "R10 no response", 0, 1);
  endtask

  task automatic do_vec(input int i);
    vec_t v;
    bit e;
    int cyc;
    int wr0;
    string tag;
    v = VEC[i];
    tag = v.off ? (v.err ? "R5" : "R4") : (v.err ? "R7" : ((v.wr != 0) ? "R2" : "R3"));
    mode = v.mode;
    wr0 = total_wr;
    pulse(v.off ? '0 : (NL'(1) << v.lane), v.off ? (NL'(1) << v.lane) : '0);
    wait_resp(int'(v.lane), e, cyc);
    chk(e == v.err, tag, int'(e), int'(v.err));
    chk(phy_rst_o == v.rst, tag, int'(phy_rst_o), int'(v.rst));
    chk(lane_idle_o[v.lane] == v.idle, tag, int'(lane_idle_o[v.lane]), int'(v.idle));
    chk(total_wr - wr0 == int'(v.wr), tag, total_wr - wr0, int'(v.wr));
    if (!v.off && !v.err && v.wr != 0)
      chk(cfg_addr_o == 6'h10, "R2 addr left on lock", int'(cfg_addr_o), 16);
    if (v.err && v.mode == M_NOLOCK)
      chk(cyc >= DL, "R6 not before deadline", cyc, DL);
    if (v.err && v.mode == M_STUCK)
      chk(cyc >= DL && cyc <= DL + 8, "R6 shared deadline", cyc, DL + 5);
    @(negedge clk_i);
    chk(done_o == '0 && err_o == '0, "R10 one cycle", int'(done_o | err_o), 0);
  endtask

  initial begin
    int t1, t2, c;
    bit rst_mid;
    int wr0;
    repeat (3) @(negedge clk_i);
    // R1
    chk(lane_idle_o == '1, "R1 idle", int'(lane_idle_o), 15);
    chk(phy_rst_o == 1'b1, "R1 rst", int'(phy_rst_o), 1);
    chk(cfg_wr_o == 1'b0 && done_o == '0 && err_o == '0, "R1 quiet",
        int'(cfg_wr_o), 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);

    for (int i = 0; i < NV; i++) do_vec(i);

    // R9: two lanes at once, lower lane first, second held while busy
    mode = M_GOOD;
    wr0 = total_wr;
    pulse(4'b0110, 4'b0000);
    t1 = -1; t2 = -1; c = 0;
    while ((t1 < 0 || t2 < 0) && c < 3000) begin
      if (done_o[1] && t1 < 0) t1 = c;
      if (done_o[2] && t2 < 0) t2 = c;
      @(negedge clk_i);
      c++;
    end
    chk(t1 >= 0 && t2 > t1, "R9 lane order", t1, t2);
    chk(total_wr - wr0 == 2, "R9 one bring-up", total_wr - wr0, 2);
    chk(lane_idle_o[2:1] == 2'b00 && !phy_rst_o, "R9 both on", int'(lane_idle_o), 9);

    pulse(4'b0000, 4'b0110);
    t1 = -1; t2 = -1; c = 0; rst_mid = 1'b1;
    while ((t1 < 0 || t2 < 0) && c < 3000) begin
      if (done_o[1] && t1 < 0) begin t1 = c; rst_mid = phy_rst_o; end
      if (done_o[2] && t2 < 0) t2 = c;
      @(negedge clk_i);
      c++;
    end
    chk(t1 >= 0 && t2 > t1, "R9 off order", t1, t2);
    chk(rst_mid == 1'b0, "R4 rst held by other user", int'(rst_mid), 0);
    chk(phy_rst_o == 1'b1 && lane_idle_o == '1, "R4 last off", int'(phy_rst_o), 1);

    // R9: on before off within one lane
    pulse(4'b1000, 4'b1000);
    t1 = -1; t2 = -1; c = 0;
    while ((t1 < 0 || t2 < 0) && c < 3000) begin
      if (done_o[3] && t1 < 0) t1 = c;
      else if ((done_o[3] || err_o[3]) && t1 >= 0 && t2 < 0) t2 = c;
      @(negedge clk_i);
      c++;
    end
    chk(t1 >= 0 && t2 > t1, "R9 on before off", t1, t2);
    chk(phy_rst_o == 1'b1 && lane_idle_o[3], "R9 lane back off", int'(phy_rst_o), 1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule